// File: doc/BRIEF.md
# MMU Fault Status Capture

This block keeps the record of address-translation faults for software. Whenever the table walker reports a fault, the block captures a status word and the page-aligned faulting virtual address. The status word packs the fault level, the fault type, the access index of the access that faulted, an address-valid flag and an overflow flag. The overflow flag is set when a second fault lands before software has consumed the first one.

On each fault the block also decides what happens to the access. If the no-fault control bit is set, or processor traps are disabled, no trap is raised. In that case the access is allowed to complete with full read, write and execute permission. Otherwise the block raises exactly one of two trap requests, one for instruction fetches and one for data accesses. The choice comes from the fetch bit of the access index.

Software reaches both registers through a small read/write port. Reading the status register returns its contents and clears it. The address register is read-only and changes only when a fault arrives.

Top module: `mmu_fault_capture`

## Requirements
- R1: After reset the status register reads 0, the address register reads 0 and no trap or grant output is asserted.
- R2: A fault arriving while the status register is 0 leaves it equal to (access index << 5) | (fault level << 8) | (fault type << 2) | 2. The level is 2 bits wide, the type and the access index are 3 bits wide, and bit 1 is the address-valid flag.
- R3: A fault arriving while the status register is nonzero first reduces it to 1 (bit 0, overflow) and then ORs in the R2 fields. The result is 1 | (access index << 5) | (level << 8) | (type << 2) | 2.
- R4: On a fault the address register captures the faulting virtual address with its low PAGE_BITS bits cleared. Register reads and writes never change it.
- R5: A read with reg_sel=0 presents the status on rd_data in the same cycle and clears the status to 0 at that clock edge. A read with reg_sel=1 presents the address register and clears nothing.
- R6: A write with reg_sel=0 loads wr_data[9:0] into the status register. A write with reg_sel=1 has no effect.
- R7: With no_fault=0 and traps_on=1, the cycle after a fault asserts trap_fetch when access index bit 1 is 1, and trap_data when it is 0. Exactly one of the two is asserted, and only for that one cycle.
- R8: With no_fault=1 or traps_on=0, a fault raises no trap. Instead, grant_rwx is asserted for the one cycle after the fault.
- R9: When a status read and a fault fall in the same cycle, the read returns the previous status. The new status holds only the R2 fields, with no overflow flag.
- R10: When a status write and a fault fall in the same cycle, the written value is the base for R2/R3. A nonzero written value therefore yields the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault strobe from the walker |
| flt_level | input | 2 | Table level at which the fault occurred |
| flt_type | input | 3 | Fault type code |
| flt_acc | input | 3 | Access index (bit 2 write, bit 1 fetch, bit 0 supervisor) |
| flt_vaddr | input | VA_W | Faulting virtual address |
| no_fault | input | 1 | No-fault mode control bit |
| traps_on | input | 1 | Processor trap-enable state |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects status, 1 selects address |
| wr_data | input | VA_W | Write data |
| rd_data | output | VA_W | Read data (combinational) |
| trap_fetch | output | 1 | Instruction access trap request |
| trap_data | output | 1 | Data access trap request |
| grant_rwx | output | 1 | Access completes with full permission |

## Verification
The bench builds the block with its defaults: a 32-bit virtual address and a 12-bit page offset. With these widths the whole fault-code space is within reach. The bench sweeps every combination of access index, level and type (256 faults) and compares each status word against its own arithmetic sum of the field weights. It checks the page-aligned address and the trap selection after every one of these faults. It also drives all four combinations of the no-fault bit and trap enable for both fetch and data faults. It covers back-to-back faults for overflow and same-cycle collisions of a fault with a status read or a status write.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int LVL_W    = 2;
  localparam int TYPE_W   = 3;
  localparam int ACC_W    = 3;
  localparam int LVL_POS  = 8;
  localparam int TYPE_POS = 2;
  localparam int ACC_POS  = 5;
  localparam int STAT_W   = LVL_POS + LVL_W;
  localparam int VALID_BIT = 1;
  localparam int OVF_BIT   = 0;
  localparam int FETCH_BIT = 1;

  // Fields contributed by one fault, including the address-valid flag.
  function automatic logic [STAT_W-1:0] fault_fields(
    input logic [LVL_W-1:0]  lvl,
    input logic [TYPE_W-1:0] typ,
    input logic [ACC_W-1:0]  acc
  );
    logic [STAT_W-1:0] f;
    f = '0;
    f[LVL_POS  +: LVL_W]  = lvl;
    f[TYPE_POS +: TYPE_W] = typ;
    f[ACC_POS  +: ACC_W]  = acc;
    f[VALID_BIT]          = 1'b1;
    return f;
  endfunction

  // Merge a new fault into an existing status word.
  function automatic logic [STAT_W-1:0] merge_fault(
    input logic [STAT_W-1:0] base,
    input logic [STAT_W-1:0] fields
  );
    logic [STAT_W-1:0] reduced;
    reduced = '0;
    reduced[OVF_BIT] = (base != '0);
    return reduced | fields;
  endfunction
endpackage

// File: rtl/mfc_status_reg.sv
module mfc_status_reg
  import mfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_hit,
  input  logic [STAT_W-1:0] fields,
  input  logic              rd_clear,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_val,
  output logic [STAT_W-1:0] stat_q
);
  logic [STAT_W-1:0] base;
  logic [STAT_W-1:0] stat_d;
  logic              ovf_event;

  always_comb begin
    if (wr_en)         base = wr_val;
    else if (rd_clear) base = '0;
    else               base = stat_q;
    stat_d = fault_hit ? merge_fault(base, fields) : base;
  end

  assign ovf_event = fault_hit && (base != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  AST_VALID_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> stat_q[VALID_BIT]); // R2
  AST_OVF_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_hit && !wr_en && !rd_clear && stat_q != '0) |=> stat_q[OVF_BIT]); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_hit && !wr_en && (rd_clear || stat_q == '0)) |=> !stat_q[OVF_BIT]); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !fault_hit && !wr_en) |=> stat_q == '0); // R5
  AST_OVF_FLAG_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_event |=> stat_q[OVF_BIT]); // R10
endmodule

// File: rtl/mfc_addr_reg.sv
module mfc_addr_reg #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fault_hit,
  input  logic [VA_W-1:0] vaddr,
  output logic [VA_W-1:0] addr_q
);
  localparam logic [VA_W-1:0] PAGE_MASK = {VA_W{1'b1}} << PAGE_BITS;

  function automatic logic [VA_W-1:0] page_align(input logic [VA_W-1:0] va);
    return va & PAGE_MASK;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         addr_q <= '0;
    else if (fault_hit) addr_q <= page_align(vaddr);
  end

  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_hit |=> $stable(addr_q)); // R4
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> addr_q[PAGE_BITS-1:0] == '0); // R4
endmodule

// File: rtl/mfc_trap_sel.sv
module mfc_trap_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_hit,
  input  logic is_fetch,
  input  logic no_fault,
  input  logic traps_on,
  output logic trap_fetch,
  output logic trap_data,
  output logic grant_rwx
);
  logic silent;
  logic raise;

  assign silent = no_fault || !traps_on;
  assign raise  = fault_hit && !silent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_fetch <= 1'b0;
      trap_data  <= 1'b0;
      grant_rwx  <= 1'b0;
    end else begin
      trap_fetch <= raise && is_fetch;
      trap_data  <= raise && !is_fetch;
      grant_rwx  <= fault_hit && silent;
    end
  end

  AST_TRAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_fetch, trap_data, grant_rwx})); // R7
  AST_SILENT_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_hit && (no_fault || !traps_on)) |=> (grant_rwx && !trap_fetch && !trap_data)); // R8
  AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_hit |=> !(trap_fetch || trap_data || grant_rwx)); // R7
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import mfc_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  input  logic [LVL_W-1:0]  flt_level,
  input  logic [TYPE_W-1:0] flt_type,
  input  logic [ACC_W-1:0]  flt_acc,
  input  logic [VA_W-1:0]   flt_vaddr,
  input  logic              no_fault,
  input  logic              traps_on,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [VA_W-1:0]   wr_data,
  output logic [VA_W-1:0]   rd_data,
  output logic              trap_fetch,
  output logic              trap_data,
  output logic              grant_rwx
);
  localparam int PAD_W = VA_W - STAT_W;

  logic [STAT_W-1:0] stat_q;
  logic [VA_W-1:0]   addr_q;
  logic [STAT_W-1:0] new_fields;
  logic              stat_rd;
  logic              stat_wr;

  assign new_fields = fault_fields(flt_level, flt_type, flt_acc);
  assign stat_rd    = reg_rd && !reg_sel;
  assign stat_wr    = reg_wr && !reg_sel;

  mfc_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .fault_hit(flt_valid), .fields(new_fields),
    .rd_clear(stat_rd), .wr_en(stat_wr), .wr_val(wr_data[STAT_W-1:0]),
    .stat_q(stat_q)
  );

  mfc_addr_reg #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_addr (
    .clk(clk), .rst_n(rst_n), .fault_hit(flt_valid), .vaddr(flt_vaddr),
    .addr_q(addr_q)
  );

  mfc_trap_sel u_trap (
    .clk(clk), .rst_n(rst_n), .fault_hit(flt_valid),
    .is_fetch(flt_acc[FETCH_BIT]), .no_fault(no_fault), .traps_on(traps_on),
    .trap_fetch(trap_fetch), .trap_data(trap_data), .grant_rwx(grant_rwx)
  );

  assign rd_data = reg_sel ? addr_q : {{PAD_W{1'b0}}, stat_q};

  AST_WRITE_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && !flt_valid) |=> $stable(addr_q)); // R6
endmodule

// File: tb/sim_mmu_fault_capture.sv
module sim_mmu_fault_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_valid = 1'b0;
  logic [1:0]  flt_level = '0;
  logic [2:0]  flt_type = '0;
  logic [2:0]  flt_acc = '0;
  logic [31:0] flt_vaddr = '0;
  logic        no_fault = 1'b0;
  logic        traps_on = 1'b1;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        trap_fetch, trap_data, grant_rwx;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mmu_fault_capture u0 (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_level(flt_level),
    .flt_type(flt_type), .flt_acc(flt_acc), .flt_vaddr(flt_vaddr),
    .no_fault(no_fault), .traps_on(traps_on), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
    .trap_fetch(trap_fetch), .trap_data(trap_data), .grant_rwx(grant_rwx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fld(input int acc, input int lvl, input int typ);
    return 32'(acc * 32 + lvl * 256 + typ * 4 + 2);
  endfunction

  // Fault strobe for one cycle; returns at the following negedge.
  task automatic fault(input int acc, input int lvl, input int typ, input logic [31:0] va);
    @(negedge clk);
    flt_valid = 1'b1; flt_acc = 3'(acc); flt_level = 2'(lvl);
    flt_type = 3'(typ); flt_vaddr = va;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] val);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = sel;
    #1 val = rd_data;
    @(negedge clk);
    reg_rd = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; wr_data = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] va;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 trap outputs", {29'd0, trap_fetch, trap_data, grant_rwx}, 32'd0);
    rd(1'b1, v); chk("R1 address reset", v, 32'd0);
    rd(1'b0, v); chk("R1 status reset", v, 32'd0);

    // Exhaustive sweep of access index x level x type.
    for (int a = 0; a < 8; a++)
      for (int l = 0; l < 4; l++)
        for (int t = 0; t < 8; t++) begin
          va = 32'((a * 32 + l * 8 + t) * 32'h0001_3579 + 32'h00AB_CDEF);
          fault(a, l, t, va);
          chk("R7 trap_fetch", {31'd0, trap_fetch}, {31'd0, a[1]});
          chk("R7 trap_data", {31'd0, trap_data}, {31'd0, ~a[1]});
          chk("R8 no grant when trapping", {31'd0, grant_rwx}, 32'd0);
          rd(1'b1, v); chk("R4 page-aligned address", v, va & 32'hFFFF_F000);
          rd(1'b0, v); chk("R2 status fields", v, fld(a, l, t));
        end
    rd(1'b0, v); chk("R5 status cleared by read", v, 32'd0);

    // Overflow on back-to-back faults.
    fault(5, 2, 3, 32'h1234_5678);
    fault(2, 1, 6, 32'h8765_4321);
    rd(1'b1, v); chk("R4 latest fault address", v, 32'h8765_4000);
    rd(1'b1, v); chk("R5 address read does not clear", v, 32'h8765_4000);
    rd(1'b0, v); chk("R3 overflow merge", v, fld(2, 1, 6) | 32'd1);

    // Silent completion modes.
    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 2; f++) begin
        no_fault = m[0]; traps_on = m[1];
        fault(f * 2, 1, 1, 32'h0000_5000);
        if (no_fault || !traps_on) begin
          chk("R8 grant", {31'd0, grant_rwx}, 32'd1);
          chk("R8 no trap", {30'd0, trap_fetch, trap_data}, 32'd0);
        end else begin
          chk("R7 trap select", {30'd0, trap_fetch, trap_data}, f ? 32'd2 : 32'd1);
          chk("R7 no grant", {31'd0, grant_rwx}, 32'd0);
        end
        rd(1'b0, v); chk("R2 status in every mode", v, fld(f * 2, 1, 1));
      end
    no_fault = 1'b0; traps_on = 1'b1;
    @(negedge clk);
    chk("R7 trap is one cycle", {29'd0, trap_fetch, trap_data, grant_rwx}, 32'd0);

    // Software write and ignored address write.
    wr(1'b0, 32'h0000_0155);
    wr(1'b1, 32'hDEAD_B000);
    rd(1'b1, v); chk("R6 address write ignored", v, 32'h0000_5000);
    rd(1'b0, v); chk("R6 status write", v, 32'h0000_0155);

    // Fault colliding with a status read.
    fault(1, 0, 0, 32'h0000_7000);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = 1'b0;
    flt_valid = 1'b1; flt_acc = 3'd6; flt_level = 2'd3; flt_type = 3'd4;
    #1 chk("R9 read returns previous", rd_data, fld(1, 0, 0));
    @(negedge clk);
    reg_rd = 1'b0; flt_valid = 1'b0;
    rd(1'b0, v); chk("R9 no overflow after read collision", v, fld(6, 3, 4));

    // Fault colliding with a status write.
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; wr_data = 32'd0;
    flt_valid = 1'b1; flt_acc = 3'd3; flt_level = 2'd2; flt_type = 3'd5;
    @(negedge clk);
    reg_wr = 1'b0; flt_valid = 1'b0;
    rd(1'b0, v); chk("R10 zero write base", v, fld(3, 2, 5));
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; wr_data = 32'h0000_0200;
    flt_valid = 1'b1; flt_acc = 3'd0; flt_level = 2'd0; flt_type = 3'd1;
    @(negedge clk);
    reg_wr = 1'b0; flt_valid = 1'b0;
    rd(1'b0, v); chk("R10 nonzero write base", v, fld(0, 0, 1) | 32'd1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule